// File: doc/BRIEF.md
# ADC serial readout controller

This block sits on the host side of a 16-bit successive-approximation converter with a serial output. It starts a conversion and reads back the result of the previous conversion while the new one runs. A data clock, made by dividing the system clock, runs at all times.

On a start request the controller pulls chip select and the read/convert line low together, on a falling edge of the data clock. The next rising edge is pulse 0. The controller releases read/convert on the falling edge of pulse 0. The rising edge of pulse 1 then asks the converter for its frame marker. The controller checks that marker on the falling edge of pulse 1 and shifts in sixteen data bits, MSB first, on the falling edges of pulses 2 to 17. It then raises chip select and presents the word with a one-cycle strobe.

Two faults end a transaction early, with an error pulse and no strobe:
- The conversion-in-progress line does not drop in time.
- The frame marker is missing.

Top module: `adc_serial_rdout`

## Requirements
- R1: While reset is held and just after it, chip select and read/convert are high (inactive), the data clock is low, and the word strobe and both error pulses are low.
- R2: The data clock toggles every DCLK_HALF system cycles, whether or not a transaction is running. Elaboration is refused if the resulting frequency is below 10 MHz, or if a half period is not longer than the 15 ns read/convert setup time.
- R3: A start request in idle makes chip select and read/convert fall in the same cycle, on a data-clock falling edge. Read/convert never falls while chip select is high.
- R4: Read/convert returns high on the falling edge of pulse 0, which is 2*DCLK_HALF system cycles after it fell.
- R5: The busy input, which is active-low, must be sampled low within floor(83 ns × clock frequency) system cycles of read/convert falling. This is 4 cycles at 50 MHz. Otherwise the busy-error output pulses for one cycle, exactly that many cycles after the fall. In the same cycle both control lines go high and no word strobe follows.
- R6: The frame-marker input, which is active-high, is sampled on the falling edge of pulse 1. If it is low, the sync-error output pulses for one cycle, 4*DCLK_HALF cycles after the start edge. Chip select goes high and no word strobe follows.
- R7: Data bits are sampled on the falling edges of pulses 2 to 17. The first bit lands in word bit 15 and the last in bit 0. The word is straight binary: 0x0000 is negative full scale, 0x8000 is midscale and 0xFFFF is full scale minus one LSB.
- R8: The word strobe is high for exactly one system cycle, 36*DCLK_HALF cycles after chip select fell. Chip select is already high in that cycle.
- R9: At the end of every transaction, good or failed, chip select is high and the ready output is high.
- R10: A start request during a running transaction is ignored. Exactly one word or error results, and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion-and-read transaction |
| ready_o | output | 1 | High while idle and able to accept a start |
| dclk_o | output | 1 | Continuous data clock to the converter |
| cs_n_o | output | 1 | Chip select, active low |
| rc_n_o | output | 1 | Read/convert, low starts a conversion |
| busy_n_i | input | 1 | Conversion in progress, active low |
| sync_i | input | 1 | Frame marker from the converter |
| sdata_i | input | 1 | Serial data from the converter |
| word_o | output | 16 | Last captured word, held until the next one |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| busy_err_o | output | 1 | One-cycle pulse: busy did not fall in time |
| sync_err_o | output | 1 | One-cycle pulse: frame marker missing |

## Verification
The hardest case to reach from the ports is the edge of the busy deadline. It is a single system cycle that decides between a good read and an abort, and that cycle also coincides with the falling edge of pulse 0, where read/convert would normally be released. The bench converter model delays its busy fall by a programmable number of cycles after it sees read/convert drop. It sweeps that delay from zero to past the deadline, so both the last accepted delay and the first rejected one are exercised. Missing-marker and mid-transaction start cases are driven through the same model.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_P0_RISE,
    ST_P0_FALL,
    ST_MARK,
    ST_DATA
  } rd_state_t;

  // whole system cycles that fit inside a time window (rounded down, so safe)
  function automatic int ns_to_cycles(input int ns, input int sys_hz);
    return (ns * (sys_hz / 1_000_000)) / 1000;
  endfunction

  // frequency of the divided data clock
  function automatic int dclk_freq(input int sys_hz, input int half);
    return sys_hz / (2 * half);
  endfunction

  // length of one data-clock half period in ns
  function automatic int half_period_ns(input int sys_hz, input int half);
    return (half * 1000) / (sys_hz / 1_000_000);
  endfunction

  // system cycles from the start edge to the falling edge of pulse k
  function automatic int fall_offset(input int k, input int half);
    return 2 * half * (k + 1);
  endfunction

endpackage

// File: rtl/adc_dclk_gen.sv
module adc_dclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic dclk_o,
  output logic rise_evt_o,
  output logic fall_evt_o
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt_q;
  logic          dclk_q;
  logic          wrap;

  assign wrap       = (cnt_q == CW'(HALF - 1));
  assign rise_evt_o = wrap && !dclk_q;
  assign fall_evt_o = wrap && dclk_q;
  assign dclk_o     = dclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      dclk_q <= !dclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R2
  dclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_evt_o && !fall_evt_o) |=> $stable(dclk_o));
endmodule

// File: rtl/adc_busy_watch.sv
module adc_busy_watch #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic clr_i,
  input  logic busy_n_i,
  output logic tmo_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign tmo_o = act_q && busy_n_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (arm_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (clr_i || !busy_n_i || tmo_o) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5
  tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |=> !tmo_o);
endmodule

// File: rtl/adc_shift_capture.sv
module adc_shift_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic         last_o,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;
  logic [W-1:0]  word_q;
  logic          valid_q;

  assign last_o  = shift_i && (cnt_q == CW'(W - 1));
  assign word_o  = word_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (shift_i) begin
        sh_q  <= {sh_q[W-2:0], bit_i};
        cnt_q <= cnt_q + 1'b1;
        if (last_o) begin
          word_q  <= {sh_q[W-2:0], bit_i};
          valid_q <= 1'b1;
        end
      end
    end
  end

  // R7
  valid_from_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(shift_i));
endmodule

// File: rtl/adc_serial_rdout.sv
module adc_serial_rdout #(
  parameter int SYS_CLK_HZ   = 50_000_000,
  parameter int DCLK_HALF    = 2,
  parameter int WORD_W       = 16,
  parameter int BUSY_MAX_NS  = 83,
  parameter int RC_SETUP_NS  = 15,
  parameter int MIN_DCLK_HZ  = 10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              ready_o,
  output logic              dclk_o,
  output logic              cs_n_o,
  output logic              rc_n_o,
  input  logic              busy_n_i,
  input  logic              sync_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              busy_err_o,
  output logic              sync_err_o
);
  import adc_rd_pkg::*;

  localparam int BUSY_CYC = ns_to_cycles(BUSY_MAX_NS, SYS_CLK_HZ);
  localparam int DCLK_HZ  = dclk_freq(SYS_CLK_HZ, DCLK_HALF);
  localparam int HALF_NS  = half_period_ns(SYS_CLK_HZ, DCLK_HALF);

  generate
    if (DCLK_HZ < MIN_DCLK_HZ) begin : g_slow_dclk
      $error("data clock divider gives a rate below the minimum");
    end
    if (HALF_NS <= RC_SETUP_NS) begin : g_short_setup
      $error("data clock half period does not cover read/convert setup");
    end
    if (BUSY_CYC < 1) begin : g_busy_window
      $error("busy window shorter than one system cycle");
    end
  endgenerate

  // named internal events
  logic dclk_rise, dclk_fall;
  logic busy_tmo, watch_arm;
  logic mark_evt, shift_evt, last_bit;
  logic cap_valid;

  rd_state_t state_q;
  logic      cs_n_q, rc_n_q, berr_q, serr_q;

  adc_dclk_gen #(.HALF(DCLK_HALF)) u_dclk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dclk_o     (dclk_o),
    .rise_evt_o (dclk_rise),
    .fall_evt_o (dclk_fall)
  );

  assign watch_arm = (state_q == ST_ARM) && dclk_fall;
  assign mark_evt  = (state_q == ST_MARK) && dclk_fall;
  assign shift_evt = (state_q == ST_DATA) && dclk_fall;

  adc_busy_watch #(.LIMIT(BUSY_CYC)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (watch_arm),
    .clr_i    (state_q == ST_IDLE),
    .busy_n_i (busy_n_i),
    .tmo_o    (busy_tmo)
  );

  adc_shift_capture #(.W(WORD_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (mark_evt),
    .shift_i (shift_evt),
    .bit_i   (sdata_i),
    .last_o  (last_bit),
    .word_o  (word_o),
    .valid_o (cap_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      rc_n_q  <= 1'b1;
      berr_q  <= 1'b0;
      serr_q  <= 1'b0;
    end else begin
      berr_q <= 1'b0;
      serr_q <= 1'b0;
      if (busy_tmo) begin
        cs_n_q  <= 1'b1;
        rc_n_q  <= 1'b1;
        berr_q  <= 1'b1;
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_i) state_q <= ST_ARM;
          ST_ARM: if (dclk_fall) begin
            cs_n_q  <= 1'b0;
            rc_n_q  <= 1'b0;
            state_q <= ST_P0_RISE;
          end
          ST_P0_RISE: if (dclk_rise) state_q <= ST_P0_FALL;
          ST_P0_FALL: if (dclk_fall) begin
            rc_n_q  <= 1'b1;
            state_q <= ST_MARK;
          end
          ST_MARK: if (dclk_fall) begin
            if (sync_i) begin
              state_q <= ST_DATA;
            end else begin
              serr_q  <= 1'b1;
              cs_n_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          ST_DATA: if (last_bit) begin
            cs_n_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign cs_n_o       = cs_n_q;
  assign rc_n_o       = rc_n_q;
  assign busy_err_o   = berr_q;
  assign sync_err_o   = serr_q;
  assign word_valid_o = cap_valid;
  assign ready_o      = (state_q == ST_IDLE);

  // R3
  rc_fall_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rc_n_o) |-> !cs_n_o);
  // R4
  rc_rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_n_o) |-> ($past(dclk_fall) || $past(busy_tmo)));
  // R5
  busy_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err_o |-> ($past(busy_n_i) && cs_n_o && rc_n_o));
  // R6
  mark_missing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_o |-> (!$past(sync_i) && cs_n_o));
  // R8
  word_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (cs_n_o && ready_o));
  // R9
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({word_valid_o, busy_err_o, sync_err_o}));
endmodule

// File: tb/tb_adc_serial_rdout.sv
module tb_adc_serial_rdout;
  localparam int HALF = 2;
  localparam int LIMIT = 4;   // floor(83 ns * 50 MHz)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ready, dclk, cs_n, rc_n, wvalid, berr, serr;
  logic [15:0] word;
  logic busy_r = 1'b1, sync_r = 1'b0, sd_r = 1'b0;

  always #10 clk = !clk;

  adc_serial_rdout dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ready_o(ready),
    .dclk_o(dclk), .cs_n_o(cs_n), .rc_n_o(rc_n), .busy_n_i(busy_r),
    .sync_i(sync_r), .sdata_i(sd_r), .word_o(word), .word_valid_o(wvalid),
    .busy_err_o(berr), .sync_err_o(serr)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model
  logic [15:0] m_word = '0;
  int m_dly = 0;
  bit m_sync = 1'b1;
  int pulse = -1, bcnt = -1;
  logic prev_rc = 1'b1, prev_dclk = 1'b0;

  always @(negedge clk) begin
    if (cs_n) begin
      busy_r = 1'b1; sync_r = 1'b0; sd_r = 1'b0; pulse = -1; bcnt = -1;
    end else begin
      if (prev_rc && !rc_n) begin
        if (m_dly == 0) busy_r = 1'b0;
        else bcnt = m_dly;
      end else if (bcnt > 0) begin
        bcnt--;
        if (bcnt == 0) busy_r = 1'b0;
      end
      if (!prev_dclk && dclk) begin
        pulse++;
        if (pulse == 1) sync_r = m_sync;
        if (pulse == 2) sync_r = 1'b0;
        if (pulse >= 2 && pulse <= 17) sd_r = m_word[17 - pulse];
      end
    end
    prev_rc = rc_n;
    prev_dclk = dclk;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic run_txn(input logic [15:0] w, input int d, input bit sen, input bit restart,
                         output int c0, output int t_rc, output int t_val, output int t_se,
                         output int t_be, output int n_ev, output logic [15:0] got);
    m_word = w; m_dly = d; m_sync = sen;
    c0 = -1; t_rc = -1; t_val = -1; t_se = -1; t_be = -1; n_ev = 0; got = '0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (restart && i == 20) start = 1'b1;
      if (restart && i == 21) start = 1'b0;
      if (c0 < 0 && !cs_n) c0 = i;
      if (c0 >= 0 && t_rc < 0 && rc_n && i > c0) t_rc = i;
      if (wvalid) begin t_val = i; got = word; n_ev++; end
      if (serr) begin t_se = i; n_ev++; end
      if (berr) begin t_be = i; n_ev++; end
      if (c0 >= 0 && cs_n) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int c0, t_rc, t_val, t_se, t_be, n_ev;
    logic [15:0] got, w;
    int last, intervals;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1, "R1 cs_n in reset", cs_n, 1);
    chk(rc_n === 1'b1, "R1 rc_n in reset", rc_n, 1);
    chk(dclk === 1'b0, "R1 dclk in reset", dclk, 0);
    chk({wvalid, berr, serr} === 3'b000, "R1 strobes in reset", {wvalid, berr, serr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === 1'b1 && rc_n === 1'b1, "R1 lines after reset", {cs_n, rc_n}, 3);

    // R2 data clock half period in idle
    last = -1; intervals = 0;
    for (int i = 0; i < 60 && intervals < 12; i++) begin
      logic pd;
      pd = dclk;
      @(negedge clk);
      if (dclk !== pd) begin
        if (last >= 0) begin
          chk(i - last == HALF, "R2 dclk half period", i - last, HALF);
          intervals++;
        end
        last = i;
      end
    end

    // R7 R8 R3 R4 word sweep
    for (int k = 0; k < 28; k++) begin
      if (k == 0) w = 16'h0000;
      else if (k == 1) w = 16'hFFFF;
      else if (k == 2) w = 16'h8000;
      else if (k == 3) w = 16'h7FFF;
      else if (k < 20) w = 16'h1 << (k - 4);
      else w = 16'((k * 16'h2F1B + 16'h0135) & 16'hFFFF);
      run_txn(w, 1, 1'b1, 1'b0, c0, t_rc, t_val, t_se, t_be, n_ev, got);
      chk(got == w, "R7 captured word", got, w);
      chk(t_val - c0 == 36 * HALF, "R8 strobe timing", t_val - c0, 36 * HALF);
      chk(n_ev == 1, "R8 single outcome", n_ev, 1);
      if (k < 4) begin
        chk(t_rc - c0 == 2 * HALF, "R4 rc release", t_rc - c0, 2 * HALF);
        chk(c0 >= 0, "R3 cs and rc fall", c0, 0);
      end
      chk(ready === 1'b1 && cs_n === 1'b1, "R9 idle after word", {ready, cs_n}, 3);
    end

    // R5 busy deadline sweep
    for (int d = 0; d <= LIMIT + 1; d++) begin
      run_txn(16'hA5C3, d, 1'b1, 1'b0, c0, t_rc, t_val, t_se, t_be, n_ev, got);
      if (d + 1 <= LIMIT) begin
        chk(t_be < 0 && t_val >= 0, "R5 busy in time accepted", t_be, -1);
        chk(got == 16'hA5C3, "R5 word after busy delay", got, 16'hA5C3);
      end else begin
        chk(t_be - c0 == LIMIT, "R5 busy error timing", t_be - c0, LIMIT);
        chk(t_val < 0 && n_ev == 1, "R5 no word after busy error", n_ev, 1);
      end
      chk(ready === 1'b1 && cs_n === 1'b1 && rc_n === 1'b1, "R9 idle after busy case",
          {ready, cs_n, rc_n}, 7);
    end

    // R6 missing frame marker
    for (int r = 0; r < 2; r++) begin
      run_txn(16'h1234, 0, 1'b0, 1'b0, c0, t_rc, t_val, t_se, t_be, n_ev, got);
      chk(t_se - c0 == 4 * HALF, "R6 sync error timing", t_se - c0, 4 * HALF);
      chk(t_val < 0 && n_ev == 1, "R6 no word after sync error", n_ev, 1);
      chk(cs_n === 1'b1, "R9 cs high after sync error", cs_n, 1);
    end

    // R10 start during transaction
    run_txn(16'h5AA5, 2, 1'b1, 1'b1, c0, t_rc, t_val, t_se, t_be, n_ev, got);
    chk(got == 16'h5AA5 && n_ev == 1, "R10 one result", n_ev, 1);
    begin
      int low = 0;
      int extra = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!cs_n) low++;
        if (wvalid || berr || serr) extra++;
      end
      chk(low == 0, "R10 no second transaction", low, 0);
      chk(extra == 0, "R10 no extra outcome", extra, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule